// File: doc/BRIEF.md
# LUT Ramp Pattern Sequencer

The sequencer walks a window of a 64-entry duty table and presents one 9-bit duty word at a time to a PWM channel. The duty word is the entry at the current position. The window is bounded by a low index and a high index. A slow tick strobe of nominally 1 kHz paces the walk. Each entry is held for a dwell time chosen by a 4-bit code. The entry at either window edge can be held longer by an optional pause.

The table is loaded through a two-byte write port. The low byte carries duty bits 7:0. The high byte carries duty bit 8 at bit 7 and the entry index in bits 5:0. Traversal has several options:
- Direction: upward from the low index, or downward from the high index.
- Ping-pong: turn around at each edge instead of jumping back to the start edge.
- Loop: repeat without end.

A run starts from a one-cycle start strobe, and only while the ramp enable is high. `busy_o` stays high for as long as the pattern is running.

Top module: `lut_ramp_seq`

## Requirements
- R1: A cycle with `lut_we_i` high stores `{lut_hi_i[7], lut_lo_i}` into entry `lut_hi_i[5:0]`. Bit 6 of `lut_hi_i` is ignored. Writes are accepted at any time.
- R2: After reset, `busy_o` is 0, every table entry is 0 and the position is index 0, so `duty_o` is 0.
- R3: A `start_i` strobe sampled while `ramp_en_i` is 1 sets `busy_o` on the next cycle. On that same cycle the position becomes the low index when `ramp_up_i` is 1, or the high index when it is 0. A strobe sampled while `ramp_en_i` is 0 has no effect.
- R4: Away from the window edges, each step moves the position by +1 when the run started with `ramp_up_i` = 1, and by -1 otherwise. `duty_o` always shows the entry at the position.
- R5: The dwell per entry, in ticks, is selected by the step code (codes 0 to 15): 0,1,2,3,4,6,8,16,18,24,32,36,64,128,256,512. A dwell of 0 acts as 1. Only cycles with `tick_i` high count toward the dwell, and `duty_o` does not change on other cycles.
- R6: Without reverse and without loop, the run ends once the far-edge entry's hold expires. `busy_o` then falls and `duty_o` keeps that entry.
- R7: With loop and without reverse, the step after the far-edge entry returns to the start edge of the window.
- R8: With reverse, reaching an edge flips the direction, and that same step moves one entry back toward the other edge. Without loop, the run ends when the hold at the start edge expires on the return leg. With loop, the traversal bounces between the edges without end.
- R9: An entry at the high index with `pause_hi_en_i` set is held for dwell × (1 + M). An entry at the low index with `pause_lo_en_i` set is held the same way. M comes from the 6-bit pause code: codes 0..15 give 1..16, code 16 gives 23, code 56 gives 7000, and codes above 56 give 7000. Without the pause, an edge entry is held for one dwell.
- R10: When `ramp_en_i` is sampled low, `busy_o` is 0 on the next cycle and the position holds.
- R11: A start strobe during a run, or after a run has ended, restarts from the start edge with a cleared dwell count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Slow pacing strobe, one cycle per tick |
| lut_we_i | input | 1 | Table write strobe |
| lut_lo_i | input | 8 | Duty bits 7:0 for a write |
| lut_hi_i | input | 8 | Bit 7: duty bit 8; bits 5:0: entry index |
| ramp_en_i | input | 1 | Ramp generator enable |
| start_i | input | 1 | Start strobe, one cycle |
| ramp_up_i | input | 1 | 1: walk low to high; 0: high to low |
| reverse_i | input | 1 | Ping-pong traversal |
| loop_i | input | 1 | Repeat without end |
| lo_idx_i | input | 6 | Low window index |
| hi_idx_i | input | 6 | High window index |
| step_code_i | input | 4 | Dwell code |
| pause_hi_en_i | input | 1 | Enable pause at the high index |
| pause_hi_code_i | input | 6 | Pause multiple code, high edge |
| pause_lo_en_i | input | 1 | Enable pause at the low index |
| pause_lo_code_i | input | 6 | Pause multiple code, low edge |
| duty_o | output | 9 | Entry at the current position |
| busy_o | output | 1 | Pattern running |

## Verification
A start strobe, a loss of enable and a dwell-completing tick all take effect at the clock edge that samples them. `duty_o` and `busy_o` are therefore correct one cycle later, and a table write shows on `duty_o` on the cycle after the write. The bench drives each strobe for exactly one cycle between falling edges. It samples at the next falling edge, so each result is read in the first cycle it is due. Dwell and pause boundaries are checked one tick before and at the expiry tick.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
  localparam int unsigned IDX_W        = 6;
  localparam int unsigned VAL_W        = 9;
  localparam int unsigned STEP_CODE_W  = 4;
  localparam int unsigned PAUSE_CODE_W = 6;
  localparam int unsigned DWELL_W      = 10;
  localparam int unsigned MULT_W       = 13;
  localparam int unsigned HOLD_W       = DWELL_W + MULT_W + 1;

  function automatic logic [DWELL_W-1:0] dwell_of(input logic [STEP_CODE_W-1:0] c);
    case (c)
      4'd0:  return 10'd0;
      4'd1:  return 10'd1;
      4'd2:  return 10'd2;
      4'd3:  return 10'd3;
      4'd4:  return 10'd4;
      4'd5:  return 10'd6;
      4'd6:  return 10'd8;
      4'd7:  return 10'd16;
      4'd8:  return 10'd18;
      4'd9:  return 10'd24;
      4'd10: return 10'd32;
      4'd11: return 10'd36;
      4'd12: return 10'd64;
      4'd13: return 10'd128;
      4'd14: return 10'd256;
      default: return 10'd512;
    endcase
  endfunction

  function automatic logic [MULT_W-1:0] mult_of(input logic [PAUSE_CODE_W-1:0] c);
    if (c < 6'd16) return MULT_W'(c) + MULT_W'(1);
    case (c)
      6'd16: return 13'd23;   6'd17: return 13'd28;   6'd18: return 13'd31;
      6'd19: return 13'd42;   6'd20: return 13'd47;   6'd21: return 13'd56;
      6'd22: return 13'd63;   6'd23: return 13'd83;   6'd24: return 13'd94;
      6'd25: return 13'd111;  6'd26: return 13'd125;  6'd27: return 13'd167;
      6'd28: return 13'd188;  6'd29: return 13'd222;  6'd30: return 13'd250;
      6'd31: return 13'd333;  6'd32: return 13'd375;  6'd33: return 13'd500;
      6'd34: return 13'd667;  6'd35: return 13'd750;  6'd36: return 13'd800;
      6'd37: return 13'd900;  6'd38: return 13'd1000; 6'd39: return 13'd1100;
      6'd40: return 13'd1200; 6'd41: return 13'd1300; 6'd42: return 13'd1400;
      6'd43: return 13'd1500; 6'd44: return 13'd1600; 6'd45: return 13'd1800;
      6'd46: return 13'd2000; 6'd47: return 13'd2500; 6'd48: return 13'd3000;
      6'd49: return 13'd3500; 6'd50: return 13'd4000; 6'd51: return 13'd4500;
      6'd52: return 13'd5000; 6'd53: return 13'd5500; 6'd54: return 13'd6000;
      6'd55: return 13'd6500;
      default: return 13'd7000;
    endcase
  endfunction
endpackage

// File: rtl/lrs_lut.sv
module lrs_lut #(
  parameter int unsigned IDX_W = 6,
  parameter int unsigned VAL_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [VAL_W-1:0] wr_val_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [VAL_W-1:0] rd_val_o
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [VAL_W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   mem_q[g] <= '0;
      else if (we_i && (wr_idx_i == IDX_W'(g)))      mem_q[g] <= wr_val_i;
    end
  end

  assign rd_val_o = mem_q[rd_idx_i];
endmodule

// File: rtl/lrs_hold.sv
module lrs_hold
  import lrs_pkg::*;
#(
  parameter int unsigned IW = IDX_W,
  parameter int unsigned HW = HOLD_W
) (
  input  logic                    [IW-1:0] idx_i,
  input  logic                    [IW-1:0] lo_idx_i,
  input  logic                    [IW-1:0] hi_idx_i,
  input  logic           [STEP_CODE_W-1:0] step_code_i,
  input  logic                             pause_hi_en_i,
  input  logic          [PAUSE_CODE_W-1:0] pause_hi_code_i,
  input  logic                             pause_lo_en_i,
  input  logic          [PAUSE_CODE_W-1:0] pause_lo_code_i,
  output logic                    [HW-1:0] limit_o
);
  logic [DWELL_W-1:0] dwell_raw, dwell;
  logic [MULT_W-1:0]  mult_sel;
  logic               at_hi, at_lo;

  always_comb begin
    dwell_raw = dwell_of(step_code_i);
    dwell     = (dwell_raw == '0) ? DWELL_W'(1) : dwell_raw;
    at_hi     = pause_hi_en_i && (idx_i == hi_idx_i);
    at_lo     = pause_lo_en_i && (idx_i == lo_idx_i);
    // high edge wins when both edges coincide
    if (at_hi)      mult_sel = mult_of(pause_hi_code_i);
    else if (at_lo) mult_sel = mult_of(pause_lo_code_i);
    else            mult_sel = '0;
    limit_o = HW'(dwell) * HW'(mult_sel + MULT_W'(1));
  end
endmodule

// File: rtl/lrs_timer.sv
module lrs_timer #(
  parameter int unsigned HW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic [HW-1:0] limit_i,
  output logic          adv_o
);
  logic [HW-1:0] cnt_q, cnt_nxt;

  assign cnt_nxt = cnt_q + HW'(1);
  assign adv_o   = run_i && tick_i && (cnt_nxt >= limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i || adv_o)  cnt_q <= '0;
    else if (run_i && tick_i) cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/lrs_walker.sv
module lrs_walker #(
  parameter int unsigned IW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          ramp_en_i,
  input  logic          adv_i,
  input  logic          ramp_up_i,
  input  logic          reverse_i,
  input  logic          loop_i,
  input  logic [IW-1:0] lo_idx_i,
  input  logic [IW-1:0] hi_idx_i,
  output logic [IW-1:0] idx_o,
  output logic          busy_o,
  output logic          restart_o
);
  logic [IW-1:0] idx_q;
  logic          up_q, back_q, busy_q;
  logic          at_end, single;

  assign restart_o = start_i && ramp_en_i;
  assign at_end    = up_q ? (idx_q >= hi_idx_i) : (idx_q <= lo_idx_i);
  assign single    = (lo_idx_i >= hi_idx_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      up_q   <= 1'b1;
      back_q <= 1'b0;
      busy_q <= 1'b0;
    end else if (restart_o) begin
      busy_q <= 1'b1;
      idx_q  <= ramp_up_i ? lo_idx_i : hi_idx_i;
      up_q   <= ramp_up_i;
      back_q <= 1'b0;
    end else if (!ramp_en_i) begin
      busy_q <= 1'b0;
    end else if (adv_i && busy_q) begin
      if (!at_end) begin
        idx_q <= up_q ? idx_q + IW'(1) : idx_q - IW'(1);
      end else if (reverse_i) begin
        if (back_q && !loop_i) begin
          busy_q <= 1'b0;
        end else begin
          up_q   <= ~up_q;
          back_q <= ~back_q;
          if (!single) idx_q <= up_q ? idx_q - IW'(1) : idx_q + IW'(1);
        end
      end else if (loop_i) begin
        idx_q <= up_q ? lo_idx_i : hi_idx_i;
      end else begin
        busy_q <= 1'b0;
      end
    end
  end

  assign idx_o  = idx_q;
  assign busy_o = busy_q;
endmodule

// File: rtl/lut_ramp_seq.sv
module lut_ramp_seq
  import lrs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       lut_we_i,
  input  logic [7:0] lut_lo_i,
  input  logic [7:0] lut_hi_i,
  input  logic       ramp_en_i,
  input  logic       start_i,
  input  logic       ramp_up_i,
  input  logic       reverse_i,
  input  logic       loop_i,
  input  logic [5:0] lo_idx_i,
  input  logic [5:0] hi_idx_i,
  input  logic [3:0] step_code_i,
  input  logic       pause_hi_en_i,
  input  logic [5:0] pause_hi_code_i,
  input  logic       pause_lo_en_i,
  input  logic [5:0] pause_lo_code_i,
  output logic [8:0] duty_o,
  output logic       busy_o
);
  logic [IDX_W-1:0]  idx;
  logic [HOLD_W-1:0] limit;
  logic              adv, restart, busy;
  logic              unused_hi_b6;

  assign unused_hi_b6 = lut_hi_i[6];

  lrs_lut #(.IDX_W(IDX_W), .VAL_W(VAL_W)) u_lut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (lut_we_i),
    .wr_idx_i (lut_hi_i[IDX_W-1:0]),
    .wr_val_i ({lut_hi_i[7], lut_lo_i}),
    .rd_idx_i (idx),
    .rd_val_o (duty_o)
  );

  lrs_hold #(.IW(IDX_W), .HW(HOLD_W)) u_hold (
    .idx_i           (idx),
    .lo_idx_i        (lo_idx_i),
    .hi_idx_i        (hi_idx_i),
    .step_code_i     (step_code_i),
    .pause_hi_en_i   (pause_hi_en_i),
    .pause_hi_code_i (pause_hi_code_i),
    .pause_lo_en_i   (pause_lo_en_i),
    .pause_lo_code_i (pause_lo_code_i),
    .limit_o         (limit)
  );

  lrs_timer #(.HW(HOLD_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (restart),
    .run_i   (busy),
    .tick_i  (tick_i),
    .limit_i (limit),
    .adv_o   (adv)
  );

  lrs_walker #(.IW(IDX_W)) u_walk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .ramp_en_i (ramp_en_i),
    .adv_i     (adv),
    .ramp_up_i (ramp_up_i),
    .reverse_i (reverse_i),
    .loop_i    (loop_i),
    .lo_idx_i  (lo_idx_i),
    .hi_idx_i  (hi_idx_i),
    .idx_o     (idx),
    .busy_o    (busy),
    .restart_o (restart)
  );

  assign busy_o = busy;
endmodule

// File: rtl/lrs_checker.sv
module lrs_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       lut_we_i,
  input logic       ramp_en_i,
  input logic       start_i,
  input logic [8:0] duty_o,
  input logic       busy_o
);
  p_start_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && ramp_en_i) |=> busy_o);

  p_en_low_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ramp_en_i |=> !busy_o);

  p_tick_gated_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && ramp_en_i && !tick_i && !start_i && !lut_we_i) |=> $stable(duty_o));

  p_idle_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i && !lut_we_i) |=> $stable(duty_o));

  p_busy_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> !busy_o);
endmodule

bind lut_ramp_seq lrs_checker u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .lut_we_i  (lut_we_i),
  .ramp_en_i (ramp_en_i),
  .start_i   (start_i),
  .duty_o    (duty_o),
  .busy_o    (busy_o)
);

// File: tb/lut_ramp_seq_tb_top.sv
`timescale 1ns/1ps
module lut_ramp_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, we = 1'b0, en = 1'b0, start = 1'b0;
  logic       up = 1'b1, rev = 1'b0, loop_en = 1'b0;
  logic [7:0] lo_b = '0, hi_b = '0;
  logic [5:0] lo = '0, hi = '0, phc = '0, plc = '0;
  logic [3:0] sc = 4'd1;
  logic       phe = 1'b0, ple = 1'b0;
  logic [8:0] duty;
  logic       busy;
  int         n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  lut_ramp_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .lut_we_i(we),
    .lut_lo_i(lo_b), .lut_hi_i(hi_b), .ramp_en_i(en), .start_i(start),
    .ramp_up_i(up), .reverse_i(rev), .loop_i(loop_en),
    .lo_idx_i(lo), .hi_idx_i(hi), .step_code_i(sc),
    .pause_hi_en_i(phe), .pause_hi_code_i(phc),
    .pause_lo_en_i(ple), .pause_lo_code_i(plc),
    .duty_o(duty), .busy_o(busy)
  );

  function automatic logic [8:0] ev(input int i);
    return 9'(i * 7 + 100);
  endfunction

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic chk_state(input string req, input int idx, input bit b);
    check({req, " duty"}, duty, ev(idx));
    check({req, " busy"}, busy, b);
  endtask

  task automatic wr(input int i, input logic [8:0] v, input bit b6);
    @(negedge clk);
    we = 1'b1; lo_b = v[7:0]; hi_b = {v[8], b6, 6'(i)};
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic cfg(input int l, input int h, input bit u, input bit r,
                     input bit lp, input int s);
    @(negedge clk);
    lo = 6'(l); hi = 6'(h); up = u; rev = r; loop_en = lp; sc = 4'(s);
    phe = 1'b0; ple = 1'b0;
  endtask

  task automatic t_reset();
    check("R2 busy", busy, 0);
    check("R2 duty", duty, 0);
  endtask

  task automatic t_load();
    for (int i = 0; i < 64; i++) wr(i, ev(i), i[0]);  // R1 bit 6 ignored on odd
    @(negedge clk);
    check("R1 entry0 on duty", duty, ev(0));
  endtask

  task automatic t_up_once();
    cfg(2, 5, 1, 0, 0, 1);
    pulse_start(); chk_state("R3 start low end", 2, 1);
    for (int i = 3; i <= 5; i++) begin ticks(1); chk_state("R4 up step", i, 1); end
    ticks(1); chk_state("R6 end hold", 5, 0);
    ticks(2); chk_state("R6 stays", 5, 0);
  endtask

  task automatic t_down_once();
    cfg(2, 5, 0, 0, 0, 1);
    pulse_start(); chk_state("R3 start high end", 5, 1);
    for (int i = 4; i >= 2; i--) begin ticks(1); chk_state("R4 down step", i, 1); end
    ticks(1); chk_state("R6 end hold down", 2, 0);
  endtask

  task automatic t_dwell();
    cfg(30, 33, 1, 0, 0, 5);  // dwell 6
    pulse_start();
    ticks(5); chk_state("R5 dwell 6 not yet", 30, 1);
    ticks(1); chk_state("R5 dwell 6 expiry", 31, 1);
    repeat (7) @(negedge clk);
    chk_state("R5 no tick no change", 31, 1);
    cfg(30, 33, 1, 0, 0, 0);  // code 0 acts as 1
    pulse_start();
    ticks(1); chk_state("R5 code0 step", 31, 1);
    ticks(1); chk_state("R5 code0 step", 32, 1);
  endtask

  task automatic t_loop();
    cfg(10, 12, 1, 0, 1, 1);
    pulse_start();
    ticks(2); chk_state("R7 far end", 12, 1);
    ticks(1); chk_state("R7 wrap to start", 10, 1);
    ticks(1); chk_state("R7 continues", 11, 1);
    @(negedge clk); en = 1'b0;
    @(negedge clk); chk_state("R10 enable drop", 11, 0);
    pulse_start(); chk_state("R3 start ignored when disabled", 11, 0);
    en = 1'b1;
  endtask

  task automatic t_rev_once();
    int exp_seq[5] = '{10, 11, 12, 11, 10};
    cfg(10, 12, 1, 1, 0, 1);
    pulse_start(); chk_state("R8 rev start", 10, 1);
    for (int k = 1; k < 5; k++) begin ticks(1); chk_state("R8 rev leg", exp_seq[k], 1); end
    ticks(1); chk_state("R8 rev end at start edge", 10, 0);
  endtask

  task automatic t_rev_loop();
    int exp_seq[7] = '{10, 11, 12, 11, 10, 11, 12};
    cfg(10, 12, 1, 1, 1, 1);
    pulse_start();
    for (int k = 1; k < 7; k++) begin ticks(1); chk_state("R8 ping-pong", exp_seq[k], 1); end
    @(negedge clk); en = 1'b0;
    @(negedge clk); en = 1'b1;
  endtask

  task automatic t_restart();
    cfg(10, 12, 1, 0, 1, 2);  // dwell 2
    pulse_start();
    ticks(2); chk_state("R11 pre", 11, 1);
    ticks(1);
    pulse_start(); chk_state("R11 restart to start edge", 10, 1);
    ticks(1); chk_state("R11 count cleared", 10, 1);
    ticks(1); chk_state("R11 first step", 11, 1);
    @(negedge clk); en = 1'b0;
    @(negedge clk); en = 1'b1;
    cfg(2, 5, 1, 0, 0, 1);
    pulse_start(); ticks(4);
    chk_state("R11 run ended", 5, 0);
    pulse_start(); chk_state("R11 start after end", 2, 1);
    ticks(4);
  endtask

  task automatic t_pause(input int code, input int mult);
    cfg(20, 22, 1, 0, 0, 1);
    @(negedge clk); phe = 1'b1; phc = 6'(code);
    pulse_start();
    ticks(2); chk_state("R9 reach high", 22, 1);
    ticks(mult); chk_state("R9 high pause pending", 22, 1);
    ticks(1); chk_state("R9 high pause expiry", 22, 0);
  endtask

  task automatic t_pause_lo();
    cfg(20, 22, 0, 0, 0, 1);
    @(negedge clk); ple = 1'b1; plc = 6'd0;  // M = 1
    pulse_start();
    ticks(1); chk_state("R9 no pause mid", 21, 1);
    ticks(1); chk_state("R9 reach low", 20, 1);
    ticks(1); chk_state("R9 low pause pending", 20, 1);
    ticks(1); chk_state("R9 low pause expiry", 20, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    en = 1'b1;
    t_load();
    t_up_once();
    t_down_once();
    t_dwell();
    t_loop();
    t_rev_once();
    t_rev_loop();
    t_restart();
    t_pause(2, 3);
    t_pause(16, 23);
    t_pause(56, 7000);
    t_pause_lo();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule